// File: doc/BRIEF.md
# Multichannel Multibank Numerically Controlled Oscillator

This block generates sine and cosine samples for several independent channels that share one datapath in turn. Each channel owns a phase accumulator. Every accepted input strobe serves the next channel in round-robin order. That channel's accumulator advances by an increment word read from a table. The table is organised as banks by channels, and a bank-select input picks the row used for each update. Changing the selected bank therefore hops a channel to another frequency, and the phase stays continuous because the accumulator is never reloaded.

Each increment word carries the frequency step in its low `ACC_W` bits and two sign-control bits above it. To produce a frequency f at per-channel output rate Fs, load the step f·2^ACC_W/Fs. When f exceeds Fs, load the fractional part of f/Fs scaled by 2^ACC_W. That keeps the step below 2^ACC_W, so it never reaches the control bits. The waveform comes from a quarter-wave table addressed by the top `LUT_AW` accumulator bits. The table is computed when the design is elaborated. A sample appears two clock cycles after its input strobe. The sample carries the channel index and the bank number it was produced with.

Top module: `mbank_nco`

## Requirements
- R1: A synchronous reset clears every accumulator, every increment table entry, the channel pointer and `out_vld`. `out_vld` is low on the cycle after any cycle with reset high, and the first samples after reset correspond to phase zero.
- R2: Each cycle with `in_vld` high serves exactly one channel, taken in the order 0, 1, …, CHANNELS-1 and then back to 0. The matching sample appears with `out_vld` high exactly 2 cycles after the strobe, and `out_chan` gives the channel index.
- R3: On each update, the served channel's accumulator becomes (accumulator + increment[ACC_W-1:0]) mod 2^ACC_W. The sample reflects the updated value. Cosine equals round(A·cos(2π(p+0.5)/2^LUT_AW)) within 1 LSB, where p is the top `LUT_AW` accumulator bits and A = 2^(OUT_W-1)-1.
- R4: Sine equals round(A·sin(2π(p+0.5)/2^LUT_AW)) within 1 LSB, using the same p, and both outputs stay within ±A.
- R5: Increment bit ACC_W negates the cosine output and bit ACC_W+1 negates the sine output. The two bits act independently and do not enter the accumulator.
- R6: `bank_sel` is sampled with `in_vld` and chooses the table row for that update. `out_bank` reports it with the sample. A bank change does not reset any accumulator.
- R7: When `wr_en` is high, `wr_data` is stored at entry (`wr_bank`, `wr_chan`). An update that reads the same entry in the same cycle uses the value held before the write.
- R8: A cycle with `in_vld` low advances no accumulator and leaves the channel pointer unchanged. Two cycles later, `out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Serve the next channel this cycle |
| bank_sel | input | BW | Table row used for this update |
| wr_en | input | 1 | Increment table write strobe |
| wr_bank | input | BW | Row of the entry written |
| wr_chan | input | CW | Channel of the entry written |
| wr_data | input | ACC_W+2 | Increment word: step in low bits, cosine flip at ACC_W, sine flip at ACC_W+1 |
| out_vld | output | 1 | Sample valid |
| out_chan | output | CW | Channel the sample belongs to |
| out_bank | output | BW | Bank used for the sample |
| out_sin | output | OUT_W | Signed sine sample |
| out_cos | output | OUT_W | Signed cosine sample |

## Verification
The hardest case to reach from the ports is a table write that lands on the same entry an update reads in that cycle. It has to coincide with the round-robin pointer, which is never visible before the sample comes out. The bench keeps its own pointer model and issues the write on the exact strobe that serves that channel. It then checks that the sample still uses the old step while the following update uses the new one. The bench also sweeps every quarter-wave address through all four quadrants on a channel with step 2^(ACC_W-LUT_AW). The other channels run with each inversion bit. Gapped strobes and random bank hops then test phase continuity.

// File: rtl/nco_pkg.sv
package nco_pkg;

   // Width of an index for n items, never below one bit.
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Quarter-wave sample: amp * sin(pi/2 * (idx + 0.5) / depth), rounded.
   // Integer Taylor series in Q30 fixed point, evaluated at elaboration.
   function automatic longint quarter_sine(input int idx, input int depth, input int amp);
      longint pi_q;
      longint x;
      longint x2;
      longint term;
      longint sum;
      pi_q = 64'sd3373259426;
      x    = (pi_q * longint'(2 * idx + 1)) / longint'(4 * depth);
      x2   = (x * x) >>> 30;
      term = x;
      sum  = x;
      for (int n = 1; n <= 7; n++) begin
         term = -((term * x2) >>> 30) / longint'(2 * n * (2 * n + 1));
         sum  = sum + term;
      end
      return (sum * longint'(amp) + (64'sd1 <<< 29)) >>> 30;
   endfunction

endpackage

// File: rtl/nco_inc_table.sv
module nco_inc_table #(
   parameter  int INC_W    = 26,
   parameter  int CHANNELS = 4,
   parameter  int BANKS    = 4,
   localparam int CW       = nco_pkg::idx_width(CHANNELS),
   localparam int BW       = nco_pkg::idx_width(BANKS),
   localparam int ENTRIES  = BANKS * CHANNELS,
   localparam int AW       = nco_pkg::idx_width(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [BW-1:0]    wr_bank,
   input  logic [CW-1:0]    wr_chan,
   input  logic [INC_W-1:0] wr_data,
   input  logic [BW-1:0]    rd_bank,
   input  logic [CW-1:0]    rd_chan,
   output logic [INC_W-1:0] rd_data
);

   logic [INC_W-1:0] words [ENTRIES];
   logic             wr_ok;
   logic             rd_ok;
   logic [AW-1:0]    wr_idx;
   logic [AW-1:0]    rd_idx;

   assign wr_ok  = (int'(wr_bank) < BANKS) && (int'(wr_chan) < CHANNELS);
   assign rd_ok  = (int'(rd_bank) < BANKS) && (int'(rd_chan) < CHANNELS);
   assign wr_idx = AW'(int'(wr_bank) * CHANNELS + int'(wr_chan));
   assign rd_idx = AW'(int'(rd_bank) * CHANNELS + int'(rd_chan));

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int e = 0; e < ENTRIES; e++) words[e] <= '0;
      end else if (wr_en && wr_ok) begin
         words[wr_idx] <= wr_data;
      end
   end

   // Read is combinational; a same-cycle write is seen only from the next edge.
   assign rd_data = rd_ok ? words[rd_idx] : '0;

endmodule

// File: rtl/nco_phase_accum.sv
module nco_phase_accum #(
   parameter  int ACC_W    = 24,
   parameter  int CHANNELS = 4,
   parameter  int TOP_W    = 10,
   localparam int CW       = nco_pkg::idx_width(CHANNELS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  logic [ACC_W-1:0] inc,
   output logic [CW-1:0]    cur_chan,
   output logic             vld_q,
   output logic [CW-1:0]    chan_q,
   output logic [TOP_W-1:0] phase_q
);

   logic [ACC_W-1:0] acc [CHANNELS];
   logic [CW-1:0]    ptr;
   logic [CW-1:0]    ptr_nxt;
   logic [ACC_W-1:0] sum;

   assign cur_chan = ptr;
   assign sum      = acc[ptr] + inc;

   if ((1 << CW) == CHANNELS) begin : g_wrap_free
      assign ptr_nxt = ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_nxt = (ptr == CW'(CHANNELS - 1)) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int c = 0; c < CHANNELS; c++) acc[c] <= '0;
         ptr     <= '0;
         vld_q   <= 1'b0;
         chan_q  <= '0;
         phase_q <= '0;
      end else begin
         vld_q <= step;
         if (step) begin
            acc[ptr] <= sum;
            ptr      <= ptr_nxt;
            chan_q   <= ptr;
            phase_q  <= sum[ACC_W-1 -: TOP_W];
         end
      end
   end

endmodule

// File: rtl/nco_wave_lut.sv
module nco_wave_lut #(
   parameter  int LUT_AW = 10,
   parameter  int OUT_W  = 16,
   localparam int QAW    = LUT_AW - 2,
   localparam int QDEPTH = 1 << QAW,
   localparam int AMP    = (1 << (OUT_W - 1)) - 1
) (
   input  logic [LUT_AW-1:0]       phase,
   input  logic [1:0]              inv,
   output logic signed [OUT_W-1:0] sin_o,
   output logic signed [OUT_W-1:0] cos_o
);

   logic [OUT_W-1:0] qtab [QDEPTH];

   for (genvar i = 0; i < QDEPTH; i++) begin : g_qtab
      localparam longint QV = nco_pkg::quarter_sine(i, QDEPTH, AMP);
      assign qtab[i] = OUT_W'(QV);
   end

   // Port 0 reads sine, port 1 reads cosine (phase advanced a quarter turn).
   logic [1:0][LUT_AW-1:0] pk;
   logic [1:0]             flip;
   logic [1:0][OUT_W-1:0]  val;

   assign pk[0]   = phase;
   assign pk[1]   = phase + LUT_AW'(QDEPTH);
   assign flip[0] = inv[1];
   assign flip[1] = inv[0];

   for (genvar k = 0; k < 2; k++) begin : g_port
      logic [QAW-1:0]   addr;
      logic [OUT_W-1:0] mag;
      assign addr   = pk[k][LUT_AW-2] ? ~pk[k][QAW-1:0] : pk[k][QAW-1:0];
      assign mag    = qtab[addr];
      assign val[k] = (pk[k][LUT_AW-1] ^ flip[k]) ? -mag : mag;
   end

   assign sin_o = $signed(val[0]);
   assign cos_o = $signed(val[1]);

endmodule

// File: rtl/mbank_nco.sv
module mbank_nco #(
   parameter  int ACC_W    = 24,
   parameter  int CHANNELS = 4,
   parameter  int BANKS    = 4,
   parameter  int LUT_AW   = 10,
   parameter  int OUT_W    = 16,
   localparam int CW       = nco_pkg::idx_width(CHANNELS),
   localparam int BW       = nco_pkg::idx_width(BANKS),
   localparam int INC_W    = ACC_W + 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_vld,
   input  logic [BW-1:0]    bank_sel,
   input  logic             wr_en,
   input  logic [BW-1:0]    wr_bank,
   input  logic [CW-1:0]    wr_chan,
   input  logic [INC_W-1:0] wr_data,
   output logic             out_vld,
   output logic [CW-1:0]    out_chan,
   output logic [BW-1:0]    out_bank,
   output logic [OUT_W-1:0] out_sin,
   output logic [OUT_W-1:0] out_cos
);

   // Elaboration-time parameter checks
   if (LUT_AW < 3 || LUT_AW > ACC_W) begin : g_bad_lut
      $error("mbank_nco: LUT_AW must lie in 3..ACC_W");
   end
   if (OUT_W < 4 || OUT_W > 24) begin : g_bad_out
      $error("mbank_nco: OUT_W must lie in 4..24");
   end
   if (CHANNELS < 1 || BANKS < 1) begin : g_bad_count
      $error("mbank_nco: CHANNELS and BANKS must be at least 1");
   end

   logic [CW-1:0]           cur_chan;
   logic [INC_W-1:0]        inc_word;
   logic                    s1_vld;
   logic [CW-1:0]           s1_chan;
   logic [LUT_AW-1:0]       s1_phase;
   logic [BW-1:0]           s1_bank;
   logic [1:0]              s1_inv;
   logic signed [OUT_W-1:0] w_sin;
   logic signed [OUT_W-1:0] w_cos;

   nco_inc_table #(
      .INC_W    (INC_W),
      .CHANNELS (CHANNELS),
      .BANKS    (BANKS)
   ) u_table (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_bank (wr_bank),
      .wr_chan (wr_chan),
      .wr_data (wr_data),
      .rd_bank (bank_sel),
      .rd_chan (cur_chan),
      .rd_data (inc_word)
   );

   nco_phase_accum #(
      .ACC_W    (ACC_W),
      .CHANNELS (CHANNELS),
      .TOP_W    (LUT_AW)
   ) u_accum (
      .clk      (clk),
      .rst      (rst),
      .step     (in_vld),
      .inc      (inc_word[ACC_W-1:0]),
      .cur_chan (cur_chan),
      .vld_q    (s1_vld),
      .chan_q   (s1_chan),
      .phase_q  (s1_phase)
   );

   // Side information travelling with stage 1
   always_ff @(posedge clk) begin
      if (rst) begin
         s1_bank <= '0;
         s1_inv  <= '0;
      end else if (in_vld) begin
         s1_bank <= bank_sel;
         s1_inv  <= inc_word[INC_W-1:ACC_W];
      end
   end

   nco_wave_lut #(
      .LUT_AW (LUT_AW),
      .OUT_W  (OUT_W)
   ) u_wave (
      .phase (s1_phase),
      .inv   (s1_inv),
      .sin_o (w_sin),
      .cos_o (w_cos)
   );

   // Stage 2: output registers
   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld  <= 1'b0;
         out_chan <= '0;
         out_bank <= '0;
         out_sin  <= '0;
         out_cos  <= '0;
      end else begin
         out_vld <= s1_vld;
         if (s1_vld) begin
            out_chan <= s1_chan;
            out_bank <= s1_bank;
            out_sin  <= w_sin;
            out_cos  <= w_cos;
         end
      end
   end

endmodule

// File: rtl/nco_checker.sv
module nco_checker #(
   parameter  int CHANNELS = 4,
   parameter  int BANKS    = 4,
   parameter  int OUT_W    = 16,
   localparam int CW       = nco_pkg::idx_width(CHANNELS),
   localparam int BW       = nco_pkg::idx_width(BANKS),
   localparam int AMP      = (1 << (OUT_W - 1)) - 1
) (
   input logic             clk,
   input logic             rst,
   input logic             in_vld,
   input logic [BW-1:0]    bank_sel,
   input logic             out_vld,
   input logic [CW-1:0]    out_chan,
   input logic [BW-1:0]    out_bank,
   input logic [OUT_W-1:0] out_sin,
   input logic [OUT_W-1:0] out_cos
);

   logic          v1, v2;
   logic [BW-1:0] b1, b2;
   logic          have_last;
   logic [CW-1:0] last_chan;
   logic [CW-1:0] next_chan;

   assign next_chan = (last_chan == CW'(CHANNELS - 1)) ? '0 : last_chan + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         v1 <= 1'b0; v2 <= 1'b0;
         b1 <= '0;   b2 <= '0;
         have_last <= 1'b0;
         last_chan <= '0;
      end else begin
         v1 <= in_vld;
         v2 <= v1;
         b1 <= bank_sel;
         b2 <= b1;
         if (out_vld) begin
            have_last <= 1'b1;
            last_chan <= out_chan;
         end
      end
   end

   assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !out_vld);

   assert_latency_R2: assert property (@(posedge clk) disable iff (rst) out_vld == v2);

   assert_first_chan_R2: assert property (@(posedge clk) disable iff (rst)
      (out_vld && !have_last) |-> out_chan == '0);

   assert_chan_order_R2: assert property (@(posedge clk) disable iff (rst)
      (out_vld && have_last) |-> out_chan == next_chan);

   assert_bank_echo_R6: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> out_bank == b2);

   assert_amplitude_R4: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (int'($signed(out_sin)) <= AMP && int'($signed(out_sin)) >= -AMP &&
                   int'($signed(out_cos)) <= AMP && int'($signed(out_cos)) >= -AMP));

endmodule

bind mbank_nco nco_checker #(
   .CHANNELS (CHANNELS),
   .BANKS    (BANKS),
   .OUT_W    (OUT_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_vld   (in_vld),
   .bank_sel (bank_sel),
   .out_vld  (out_vld),
   .out_chan (out_chan),
   .out_bank (out_bank),
   .out_sin  (out_sin),
   .out_cos  (out_cos)
);

// File: tb/sim_mbank_nco.sv
`timescale 1ns/1ps
module sim_mbank_nco;

   localparam int N   = 12;
   localparam int C   = 3;
   localparam int B   = 2;
   localparam int M   = 8;
   localparam int W   = 12;
   localparam int CW  = 2;
   localparam int BW  = 1;
   localparam int AMP = (1 << (W - 1)) - 1;
   localparam real PI = 3.14159265358979323846;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_vld = 1'b0;
   logic [BW-1:0] bank_sel = '0;
   logic          wr_en = 1'b0;
   logic [BW-1:0] wr_bank = '0;
   logic [CW-1:0] wr_chan = '0;
   logic [N+1:0]  wr_data = '0;
   logic          out_vld;
   logic [CW-1:0] out_chan;
   logic [BW-1:0] out_bank;
   logic [W-1:0]  out_sin;
   logic [W-1:0]  out_cos;

   always #2.5 clk = ~clk;

   mbank_nco #(.ACC_W(N), .CHANNELS(C), .BANKS(B), .LUT_AW(M), .OUT_W(W)) u0 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .bank_sel(bank_sel),
      .wr_en(wr_en), .wr_bank(wr_bank), .wr_chan(wr_chan), .wr_data(wr_data),
      .out_vld(out_vld), .out_chan(out_chan), .out_bank(out_bank),
      .out_sin(out_sin), .out_cos(out_cos));

   typedef struct {
      bit    v;
      int    ch;
      int    bk;
      real   s;
      real   c;
      bit    si;
      bit    ci;
      string tag;
   } exp_t;

   int     n_tests = 0;
   int     n_fail  = 0;
   longint m_tab [B][C];
   longint m_acc [C];
   int     m_ptr;
   exp_t   p0, p1;
   bit     finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic exp_t idle_item();
      exp_t e;
      e.v = 0; e.ch = 0; e.bk = 0; e.s = 0.0; e.c = 0.0; e.si = 0; e.ci = 0; e.tag = "";
      return e;
   endfunction

   task automatic check_item(input exp_t e);
      real ds, dc;
      if (!e.v) begin
         chk(out_vld == 1'b0, "R8", "out_vld idle", longint'(out_vld), 0);
      end else begin
         chk(out_vld == 1'b1, "R2", "out_vld", longint'(out_vld), 1);
         chk(int'(out_chan) == e.ch, "R2", "out_chan", longint'(out_chan), longint'(e.ch));
         chk(int'(out_bank) == e.bk, "R6", "out_bank", longint'(out_bank), longint'(e.bk));
         ds = real'(int'($signed(out_sin))) - e.s;
         dc = real'(int'($signed(out_cos))) - e.c;
         if (ds < 0.0) ds = -ds;
         if (dc < 0.0) dc = -dc;
         chk(ds <= 1.0, (e.tag != "") ? e.tag : (e.si ? "R5" : "R4"), "out_sin",
             longint'($signed(out_sin)), longint'($rtoi(e.s)));
         chk(dc <= 1.0, (e.tag != "") ? e.tag : (e.ci ? "R5" : "R3"), "out_cos",
             longint'($signed(out_cos)), longint'($rtoi(e.c)));
      end
   endtask

   // One clock: check the sample due now, update the model, drive the inputs.
   task automatic cycle(input bit v, input int bk, input bit we, input int wb,
                        input int wc, input longint wd, input string tag);
      exp_t   e;
      longint inc;
      longint p;
      real    ang;
      @(negedge clk);
      check_item(p1);
      p1 = p0;
      e = idle_item();
      if (v) begin
         inc = m_tab[bk][m_ptr];
         m_acc[m_ptr] = (m_acc[m_ptr] + (inc & ((64'sd1 << N) - 1))) & ((64'sd1 << N) - 1);
         p   = m_acc[m_ptr] >> (N - M);
         ang = 2.0 * PI * (real'(p) + 0.5) / real'(1 << M);
         e.v  = 1;
         e.ch = m_ptr;
         e.bk = bk;
         e.ci = inc[N];
         e.si = inc[N+1];
         e.s  = real'(AMP) * $sin(ang) * (e.si ? -1.0 : 1.0);
         e.c  = real'(AMP) * $cos(ang) * (e.ci ? -1.0 : 1.0);
         e.tag = tag;
         m_ptr = (m_ptr + 1) % C;
      end
      p0 = e;
      if (we) m_tab[wb][wc] = wd;
      in_vld   = v;
      bank_sel = BW'(bk);
      wr_en    = we;
      wr_bank  = BW'(wb);
      wr_chan  = CW'(wc);
      wr_data  = (N+2)'(wd);
   endtask

   task automatic run(input int n, input int bk);
      for (int i = 0; i < n; i++) cycle(1'b1, bk, 1'b0, 0, 0, 0, "");
   endtask

   task automatic wr(input int wb, input int wc, input longint wd);
      cycle(1'b0, 0, 1'b1, wb, wc, wd, "");
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_vld = 1'b0; wr_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(out_vld == 1'b0, "R1", "out_vld in reset", longint'(out_vld), 0);
      rst = 1'b0;
      for (int b = 0; b < B; b++)
         for (int c = 0; c < C; c++) m_tab[b][c] = 0;
      for (int c = 0; c < C; c++) m_acc[c] = 0;
      m_ptr = 0;
      p0 = idle_item();
      p1 = idle_item();
   endtask

   task automatic flush();
      for (int i = 0; i < 3; i++) cycle(1'b0, 0, 1'b0, 0, 0, 0, "");
   endtask

   initial begin : main
      logic [15:0] lfsr;
      int          bk;
      lfsr = 16'hACE1;
      bk   = 0;
      do_reset();
      // R1: after reset the table is zero, so every channel sits at phase zero
      for (int i = 0; i < 6; i++) cycle(1'b1, i % B, 1'b0, 0, 0, 0, "R1");
      flush();
      chk(out_vld == 1'b0, "R1", "idle after reset stream", longint'(out_vld), 0);

      // Load both banks; bit N flips cosine, bit N+1 flips sine (R5, R7)
      wr(0, 0, 16);
      wr(0, 1, 16 | (1 << N));
      wr(0, 2, 48 | (1 << (N + 1)));
      wr(1, 0, 4095 | (3 << N));
      wr(1, 1, 1000);
      wr(1, 2, 2048 | (1 << (N + 1)));
      flush();

      // Exhaustive table sweep: channel 0 visits all 2^M addresses (R3, R4)
      run(800, 0);
      // Maximum step wraps each update (R3)
      run(60, 1);

      // Gapped strobes with random bank hops (R6, R8)
      for (int i = 0; i < 2400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[3:0] == 4'h0) bk = 1 - bk;
         cycle(lfsr[7] | lfsr[9], bk, 1'b0, 0, 0, 0, "");
      end
      flush();

      // R7: write hits the entry being read on the same strobe
      cycle(1'b1, 0, 1'b1, 0, m_ptr, 200 | (1 << N), "R7");
      cycle(1'b1, 0, 1'b0, 0, 0, 0, "R7");
      cycle(1'b1, 0, 1'b0, 0, 0, 0, "R7");
      cycle(1'b1, 0, 1'b0, 0, 0, 0, "R7");
      run(30, 0);

      // Mid-stream reset returns all channels to phase zero (R1)
      do_reset();
      for (int i = 0; i < 6; i++) cycle(1'b1, 1, 1'b0, 0, 0, 0, "R1");
      wr(1, 2, 700 | (3 << N));
      run(300, 1);
      flush();

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule